// File: doc/BRIEF.md
# USB Endpoint FIFO DMA Requester

This block joins two USB device endpoint buffers to an external byte-wide DMA controller. The first endpoint is an OUT endpoint: the USB side writes a received packet into its buffer, and the DMA drains that buffer. The second endpoint is an IN endpoint: the DMA fills its buffer, and the USB side then drains it onto the bus. Each endpoint raises a DMA request. The two requests are merged into one active-low request line.

When DMA mode is on for an endpoint, the buffer state moves on its own. A fully drained receive buffer returns to empty with no software trigger. A transmit buffer that reaches the maximum packet size becomes ready to send. An empty received packet is dropped. A transmit packet shorter than the maximum still needs a software packet-enable pulse. When DMA mode is off, the receive side needs a read-done pulse and the transmit side needs the packet-enable pulse. Out-of-turn DMA accesses are ignored and set sticky error flags.

Top module: `epdma_bridge`

## Requirements
- R1: With the OUT DMA enable set, `dreq_n` is low one cycle after the OUT buffer holds at least one unread byte, and the bytes come out of `dma_rd_data` in arrival order, one cycle after each `dma_rd` strobe.
- R2: With the IN DMA enable set, `dreq_n` is low while the IN buffer is not ready to transmit, and it goes high one cycle after the buffer becomes ready.
- R3: `dreq_n` is the registered inverse of the OR of both endpoint requests. It stays low as long as any request is pending, whatever the DMA strobes do.
- R4: With the OUT DMA enable set, a packet end with no bytes leaves the OUT buffer empty, so `rx_nak` and `dreq_n` do not change.
- R5: With the OUT DMA enable set, the read of the last unread byte returns the OUT buffer to empty (`rx_nak` low on the next cycle), with no read-done pulse.
- R6: With the IN DMA enable set, the write of byte number MAXPKT (64 by default) makes `tx_ready` rise on the next cycle, with `tx_len` = 64.
- R7: A fill shorter than MAXPKT leaves `tx_ready` low until an `ep2_pkt_en` pulse. After the pulse, `tx_len` equals the number of bytes written.
- R8: The OUT buffer holds one packet. `rx_nak` is high from the cycle after a packet end until the buffer is empty again, and bytes offered during that time are dropped.
- R9: A `tx_done` pulse returns the IN buffer to empty (`tx_ready` low), and with the IN DMA enable set, `dreq_n` goes low again. `tx_data` gives the buffered bytes in write order, one cycle after each `tx_rd`.
- R10: A `dma_rd` with no unread OUT byte, or a `dma_wr` while the IN buffer is ready or holds MAXPKT bytes, is ignored and sets the sticky flag `rd_err` or `wr_err` respectively, until reset.
- R11: With a DMA enable clear, that endpoint raises no request. The OUT buffer returns to empty only on `ep1_rd_done`, and the IN buffer does not become ready at MAXPKT without `ep2_pkt_en`.
- R12: After synchronous reset, `dreq_n`=1, `rx_nak`=0, `tx_ready`=0, `tx_len`=0, `rd_err`=0 and `wr_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ep1_dma_en | input | 1 | DMA mode for the OUT endpoint |
| ep2_dma_en | input | 1 | DMA mode for the IN endpoint |
| ep1_rd_done | input | 1 | Software read-finished pulse for the OUT endpoint |
| ep2_pkt_en | input | 1 | Software packet-ready pulse for the IN endpoint |
| rx_byte_vld | input | 1 | Received byte strobe from the USB side |
| rx_byte | input | 8 | Received byte |
| rx_pkt_end | input | 1 | End of received packet |
| rx_nak | output | 1 | OUT buffer occupied; USB side must NAK |
| dma_rd | input | 1 | DMA byte read strobe (OUT endpoint) |
| dma_rd_data | output | 8 | Byte read by the DMA, valid the cycle after `dma_rd` |
| dma_wr | input | 1 | DMA byte write strobe (IN endpoint) |
| dma_wr_data | input | 8 | Byte written by the DMA |
| tx_ready | output | 1 | IN packet ready to transmit |
| tx_len | output | 7 | IN packet length in bytes |
| tx_rd | input | 1 | USB-side transmit byte read strobe |
| tx_data | output | 8 | Transmit byte, valid the cycle after `tx_rd` |
| tx_done | input | 1 | USB side finished sending the IN packet |
| dreq_n | output | 1 | Merged active-low DMA request |
| rd_err | output | 1 | Sticky flag: DMA read with no unread byte |
| wr_err | output | 1 | Sticky flag: DMA write refused |

## Verification
The assertions assume that the strobes and triggers are single-cycle pulses sampled at the rising edge. They also assume that `rst` is held high from time zero until the first edge, so that no property sees the buffers' power-up state. The stimulus drives every input on the falling edge and returns each strobe to zero one cycle later. It issues `tx_done` only when a packet is ready, and it holds each DMA enable constant within a scenario. That keeps the automatic state changes apart from changes of mode.

// File: rtl/epdma_pkg.sv
package epdma_pkg;
  typedef enum logic {
    RX_EMPTY = 1'b0,
    RX_HELD  = 1'b1
  } rx_state_e;

  typedef enum logic {
    TX_FILL  = 1'b0,
    TX_READY = 1'b1
  } tx_state_e;
endpackage

// File: rtl/epdma_ram.sv
module epdma_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/epdma_rx_ep.sv
module epdma_rx_ep
  import epdma_pkg::*;
#(
  parameter int DW     = 8,
  parameter int MAXPKT = 64,
  localparam int CW    = $clog2(MAXPKT + 1),
  localparam int AW    = $clog2(MAXPKT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dma_en,
  input  logic          rd_done_trg,
  input  logic          in_vld,
  input  logic [DW-1:0] in_byte,
  input  logic          in_end,
  output logic          nak,
  input  logic          rd,
  output logic [DW-1:0] rd_data,
  output logic          req,
  output logic          rd_err
);
  localparam logic [CW-1:0] MAXC = CW'(MAXPKT);

  rx_state_e     st;
  logic [CW-1:0] cnt, rptr, cnt_nxt;
  logic          accept, rd_ok, last_rd;

  assign accept  = (st == RX_EMPTY) && in_vld && (cnt < MAXC);
  assign cnt_nxt = cnt + CW'(accept);
  assign rd_ok   = (st == RX_HELD) && rd && (rptr < cnt);
  assign last_rd = rd_ok && (rptr + CW'(1) == cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= RX_EMPTY;
      cnt    <= '0;
      rptr   <= '0;
      rd_err <= 1'b0;
    end else begin
      if (rd && !rd_ok) rd_err <= 1'b1;
      case (st)
        RX_EMPTY: begin
          cnt <= cnt_nxt;
          if (in_end) begin
            if (cnt_nxt == '0 && dma_en) begin
              cnt <= '0;
            end else begin
              st   <= RX_HELD;
              rptr <= '0;
            end
          end
        end
        default: begin
          if (rd_ok) rptr <= rptr + CW'(1);
          if ((dma_en && last_rd) || rd_done_trg) begin
            st   <= RX_EMPTY;
            cnt  <= '0;
            rptr <= '0;
          end
        end
      endcase
    end
  end

  assign nak = (st == RX_HELD);
  assign req = dma_en && (st == RX_HELD) && (rptr < cnt);

  epdma_ram #(.DW(DW), .DEPTH(MAXPKT)) u_ram (
    .clk  (clk),
    .we   (accept),
    .waddr(cnt[AW-1:0]),
    .wdata(in_byte),
    .re   (rd_ok),
    .raddr(rptr[AW-1:0]),
    .rdata(rd_data)
  );

  // R8
  held_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (st == RX_HELD && in_vld && !rd_done_trg && !rd_ok) |=> $stable(cnt));
  // R4
  zlp_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (st == RX_EMPTY && cnt == '0 && !in_vld && in_end && dma_en) |=> (st == RX_EMPTY));
  // R5
  auto_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (st == RX_HELD && dma_en && last_rd) |=> (st == RX_EMPTY && cnt == '0));
  // R10
  rd_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    rd_err |=> rd_err);
endmodule

// File: rtl/epdma_tx_ep.sv
module epdma_tx_ep
  import epdma_pkg::*;
#(
  parameter int DW     = 8,
  parameter int MAXPKT = 64,
  localparam int CW    = $clog2(MAXPKT + 1),
  localparam int AW    = $clog2(MAXPKT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dma_en,
  input  logic          pkt_en_trg,
  input  logic          wr,
  input  logic [DW-1:0] wr_data,
  output logic          wr_err,
  output logic          req,
  output logic          ready,
  output logic [CW-1:0] len,
  input  logic          out_rd,
  output logic [DW-1:0] out_data,
  input  logic          out_done
);
  localparam logic [CW-1:0] MAXC = CW'(MAXPKT);

  tx_state_e     st;
  logic [CW-1:0] wcnt, tptr;
  logic          wr_ok, out_ok, fill_last;

  assign wr_ok     = (st == TX_FILL) && wr && (wcnt < MAXC);
  assign out_ok    = (st == TX_READY) && out_rd && (tptr < wcnt);
  assign fill_last = wr_ok && (wcnt == MAXC - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= TX_FILL;
      wcnt   <= '0;
      tptr   <= '0;
      wr_err <= 1'b0;
    end else begin
      if (wr && !wr_ok) wr_err <= 1'b1;
      case (st)
        TX_FILL: begin
          if (wr_ok) wcnt <= wcnt + CW'(1);
          if ((dma_en && fill_last) || pkt_en_trg) begin
            st   <= TX_READY;
            tptr <= '0;
          end
        end
        default: begin
          if (out_ok) tptr <= tptr + CW'(1);
          if (out_done) begin
            st   <= TX_FILL;
            wcnt <= '0;
            tptr <= '0;
          end
        end
      endcase
    end
  end

  assign req   = dma_en && (st == TX_FILL);
  assign ready = (st == TX_READY);
  assign len   = wcnt;

  epdma_ram #(.DW(DW), .DEPTH(MAXPKT)) u_ram (
    .clk  (clk),
    .we   (wr_ok),
    .waddr(wcnt[AW-1:0]),
    .wdata(wr_data),
    .re   (out_ok),
    .raddr(tptr[AW-1:0]),
    .rdata(out_data)
  );

  // R6
  auto_full_chk: assert property (@(posedge clk) disable iff (rst)
    (st == TX_FILL && dma_en && fill_last) |=> (st == TX_READY && wcnt == MAXC));
  // R10
  wr_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (st == TX_READY && wr && !out_done) |=> ($stable(wcnt) && wr_err));
  // R9
  done_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (st == TX_READY && out_done) |=> (st == TX_FILL && wcnt == '0));
endmodule

// File: rtl/epdma_dreq.sv
module epdma_dreq #(
  parameter int NREQ = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREQ-1:0] req,
  output logic            dreq_n
);
  always_ff @(posedge clk) begin
    if (rst) dreq_n <= 1'b1;
    else     dreq_n <= ~(|req);
  end

  // R3
  dreq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |=> !dreq_n);
  // R3
  dreq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |=> dreq_n);
endmodule

// File: rtl/epdma_bridge.sv
module epdma_bridge #(
  parameter int DW     = 8,
  parameter int MAXPKT = 64,
  localparam int CW    = $clog2(MAXPKT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ep1_dma_en,
  input  logic          ep2_dma_en,
  input  logic          ep1_rd_done,
  input  logic          ep2_pkt_en,
  input  logic          rx_byte_vld,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_pkt_end,
  output logic          rx_nak,
  input  logic          dma_rd,
  output logic [DW-1:0] dma_rd_data,
  input  logic          dma_wr,
  input  logic [DW-1:0] dma_wr_data,
  output logic          tx_ready,
  output logic [CW-1:0] tx_len,
  input  logic          tx_rd,
  output logic [DW-1:0] tx_data,
  input  logic          tx_done,
  output logic          dreq_n,
  output logic          rd_err,
  output logic          wr_err
);
  logic [1:0] ep_req;

  epdma_rx_ep #(.DW(DW), .MAXPKT(MAXPKT)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .dma_en     (ep1_dma_en),
    .rd_done_trg(ep1_rd_done),
    .in_vld     (rx_byte_vld),
    .in_byte    (rx_byte),
    .in_end     (rx_pkt_end),
    .nak        (rx_nak),
    .rd         (dma_rd),
    .rd_data    (dma_rd_data),
    .req        (ep_req[0]),
    .rd_err     (rd_err)
  );

  epdma_tx_ep #(.DW(DW), .MAXPKT(MAXPKT)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .dma_en    (ep2_dma_en),
    .pkt_en_trg(ep2_pkt_en),
    .wr        (dma_wr),
    .wr_data   (dma_wr_data),
    .wr_err    (wr_err),
    .req       (ep_req[1]),
    .ready     (tx_ready),
    .len       (tx_len),
    .out_rd    (tx_rd),
    .out_data  (tx_data),
    .out_done  (tx_done)
  );

  epdma_dreq #(.NREQ(2)) u_dreq (
    .clk   (clk),
    .rst   (rst),
    .req   (ep_req),
    .dreq_n(dreq_n)
  );

  // R11
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!ep1_dma_en && !ep2_dma_en && !$past(ep1_dma_en) && !$past(ep2_dma_en)
     && !$past(rst)) |-> dreq_n);
endmodule

// File: tb/sim_epdma_bridge.sv
module sim_epdma_bridge;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ep1_dma_en = 0, ep2_dma_en = 0, ep1_rd_done = 0, ep2_pkt_en = 0;
  logic       rx_byte_vld = 0, rx_pkt_end = 0, dma_rd = 0, dma_wr = 0;
  logic       tx_rd = 0, tx_done = 0;
  logic [7:0] rx_byte = 0, dma_wr_data = 0;
  logic       rx_nak, tx_ready, dreq_n, rd_err, wr_err;
  logic [7:0] dma_rd_data, tx_data;
  logic [6:0] tx_len;
  int         n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  epdma_bridge u0 (.*);

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; tick(); tick(); rst = 0;
    ep1_dma_en = 0; ep2_dma_en = 0;
  endtask

  task automatic send_pkt(int n, logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      rx_byte_vld = 1; rx_byte = base + 8'(i); tick();
    end
    rx_byte_vld = 0; rx_pkt_end = 1; tick(); rx_pkt_end = 0;
  endtask

  task automatic dma_read(logic [7:0] exp, string rq);
    dma_rd = 1; tick(); dma_rd = 0;
    chk(rq, dma_rd_data, exp);
  endtask

  task automatic dma_write(logic [7:0] d);
    dma_wr = 1; dma_wr_data = d; tick(); dma_wr = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12 dreq_n", dreq_n, 1); chk("R12 rx_nak", rx_nak, 0);
    chk("R12 tx_ready", tx_ready, 0); chk("R12 tx_len", tx_len, 0);
    chk("R12 errs", {rd_err, wr_err}, 0);
  endtask

  task automatic t_rx_dma();
    do_reset(); ep1_dma_en = 1;
    send_pkt(5, 8'hA0);
    chk("R8 nak after end", rx_nak, 1);
    tick(); chk("R1 dreq low", dreq_n, 0);
    for (int i = 0; i < 5; i++) begin
      dma_read(8'hA0 + 8'(i), "R1 data order");
      if (i < 4) chk("R3 dreq held", dreq_n, 0);
    end
    chk("R5 auto empty", rx_nak, 0);
    tick(); chk("R5 dreq released", dreq_n, 1);
    chk("R10 no err", rd_err, 0);
  endtask

  task automatic t_zlp();
    do_reset(); ep1_dma_en = 1;
    send_pkt(0, 8'h00);
    chk("R4 nak", rx_nak, 0);
    tick(); chk("R4 dreq", dreq_n, 1);
  endtask

  task automatic t_nak();
    do_reset(); ep1_dma_en = 1;
    send_pkt(3, 8'h10);
    send_pkt(2, 8'h50);
    chk("R8 still nak", rx_nak, 1);
    for (int i = 0; i < 3; i++) dma_read(8'h10 + 8'(i), "R8 original data");
    chk("R8 empty", rx_nak, 0);
    dma_rd = 1; tick(); dma_rd = 0;
    chk("R10 rd_err", rd_err, 1);
    tick(); chk("R10 rd_err sticky", rd_err, 1);
  endtask

  task automatic t_tx_full();
    do_reset(); ep2_dma_en = 1;
    tick(); chk("R2 dreq low", dreq_n, 0);
    for (int i = 0; i < 64; i++) begin
      if (i == 63) chk("R6 not ready at 63", tx_ready, 0);
      dma_write(8'(i * 3));
    end
    chk("R6 ready", tx_ready, 1); chk("R6 len", tx_len, 64);
    tick(); chk("R2 dreq high", dreq_n, 1);
    dma_write(8'hEE);
    chk("R10 wr_err", wr_err, 1); chk("R10 len kept", tx_len, 64);
    for (int i = 0; i < 4; i++) begin
      tx_rd = 1; tick(); tx_rd = 0;
      chk("R9 tx data", tx_data, 8'(i * 3));
    end
    tx_done = 1; tick(); tx_done = 0;
    chk("R9 empty", tx_ready, 0);
    tick(); chk("R9 dreq again", dreq_n, 0);
  endtask

  task automatic t_tx_short();
    do_reset(); ep2_dma_en = 1;
    for (int i = 0; i < 10; i++) dma_write(8'h30 + 8'(i));
    tick(); chk("R7 not ready", tx_ready, 0);
    ep2_pkt_en = 1; tick(); ep2_pkt_en = 0;
    chk("R7 ready", tx_ready, 1); chk("R7 len", tx_len, 10);
    tx_rd = 1; tick(); tx_rd = 0;
    chk("R9 first byte", tx_data, 8'h30);
  endtask

  task automatic t_dma_off();
    do_reset();
    send_pkt(2, 8'h70);
    tick(); chk("R11 no ep1 req", dreq_n, 1);
    dma_read(8'h70, "R11 read"); dma_read(8'h71, "R11 read");
    tick(); chk("R11 held w/o trigger", rx_nak, 1);
    ep1_rd_done = 1; tick(); ep1_rd_done = 0;
    chk("R11 empty on trigger", rx_nak, 0);
    for (int i = 0; i < 64; i++) dma_write(8'(i));
    tick(); chk("R11 not ready at max", tx_ready, 0);
    chk("R11 dreq", dreq_n, 1);
    ep2_pkt_en = 1; tick(); ep2_pkt_en = 0;
    chk("R11 ready", tx_ready, 1); chk("R11 len", tx_len, 64);
  endtask

  initial begin
    tick();
    t_reset(); t_rx_dma(); t_zlp(); t_nak();
    t_tx_full(); t_tx_short(); t_dma_off();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule